// File: doc/BRIEF.md
# LED Pixel FIFO and Interrupt Front End

This block sits between the register bus and the waveform serializer of an addressable-LED controller. Software or a DMA engine writes 32-bit pixel words to a data address. The words are queued in a 32-entry FIFO and handed to the serializer over a valid/ready port while a frame is running. A control write with the enable bit set does three things: it starts the frame, loads the frame length for the serializer, and flushes any words left over from an earlier frame.

A single programmable trigger level decides when the FIFO needs refilling. When DMA is enabled, a low fill level raises a DMA request line. Otherwise it sets a data-request status flag that can interrupt the processor. The serializer reports end of frame with a one-cycle pulse. That pulse latches a transfer-finished flag and ends the run. A sticky overflow flag records writes that found the FIFO full. Status reads also show the live fill level. All flags are cleared by writing ones.

Top module: `ledc_fifo_front`

Register map (byte offsets on `reg_addr_i`):
- 0x00 control: bit 0 enable/run, bits 28:16 frame length.
- 0x04 data: write pushes a word, read returns zero.
- 0x08 DMA: bit 5 DMA enable, bits 4:0 trigger level.
- 0x0C interrupt enable: bit 5 global, bit 1 data request, bit 0 finished.
- 0x10 status: bits 15:10 fill level, bit 2 overflow, bit 1 data request, bit 0 finished.

## Requirements
- R1: After reset the status register reads 0 in the fill-level, overflow and finished fields, and the trigger field of the DMA register reads 16. After reset `irq_o`, `dma_req_o`, `run_o` and `pix_valid_o` are all low.
- R2: Words written to the data address leave on `pix_data_o` in write order, one per cycle with both `pix_valid_o` and `pix_ready_i` high. `pix_valid_o` is high only while `run_o` is high and the FIFO holds data, and the word is held stable while it waits for `pix_ready_i`.
- R3: Status bits 15:10 give the number of words held, at most 32. A data write to a full FIFO is dropped and sets overflow flag bit 2, which stays set until it is cleared.
- R4: Reading the data address returns zero.
- R5: With DMA enable (DMA register bit 5) set, `dma_req_o` is high exactly when the fill level is at or below the trigger level (bits 4:0), and the data-request flag is not set. With DMA enable clear, `dma_req_o` is low.
- R6: With DMA enable clear, the data-request flag (status bit 1) sets on the clock edge after the fill level is at or below the trigger level. It sets again on every such edge while the condition holds.
- R7: A pulse on `xfer_done_i` sets the finished flag (status bit 0) and drops `run_o`.
- R8: Writing the status register clears each flag whose bit is written as one and leaves the others. A flag being set in the same cycle wins over its clear.
- R9: `irq_o` is high when the global enable is set and either the finished flag and its enable are both set, or the data-request flag and its enable are both set.
- R10: A control write with bit 0 set empties the FIFO, raises `run_o` and loads bits 28:16 onto `frame_len_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| xfer_done_i | input | 1 | End-of-frame pulse from the serializer |
| run_o | output | 1 | Frame in progress |
| frame_len_o | output | 13 | Frame length in pixels |
| pix_valid_o | output | 1 | Pixel word available |
| pix_ready_i | input | 1 | Serializer accepts the pixel word |
| pix_data_o | output | 32 | Pixel word |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
A register write takes effect on the clock edge that samples it. Any read of the fill level, `run_o`, `frame_len_o` or `pix_data_o` done at the next falling edge therefore already shows the new state. The data-request flag is registered from the fill level, so it lags one edge. The bench either writes a W1C clear and reads afterwards, or waits one extra idle cycle before sampling it. `dma_req_o` and `irq_o` follow the registered state combinationally, so they are sampled in the same falling-edge window as the state they depend on.

// File: rtl/ledc_pkg.sv
package ledc_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DW     = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_DATA = 5'h04;
  localparam logic [ADDR_W-1:0] A_DMA  = 5'h08;
  localparam logic [ADDR_W-1:0] A_IEN  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h10;

  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_LEN     = 16;
  localparam int unsigned B_DMA_EN  = 5;
  localparam int unsigned B_GLB_EN  = 5;
  localparam int unsigned B_REQ     = 1;
  localparam int unsigned B_FIN     = 0;
  localparam int unsigned B_OVF     = 2;
  localparam int unsigned B_LVL     = 10;

  // flag vector order: {ovf, req, fin}
  typedef struct packed {
    logic ovf;
    logic req;
    logic fin;
  } flags_t;
endpackage

// File: rtl/ledc_word_fifo.sv
module ledc_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rd_q];
  assign level_o = cnt_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= inc(wr_q);
      if (pop_ok)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end
endmodule

// File: rtl/ledc_irq_ctrl.sv
module ledc_irq_ctrl
  import ledc_pkg::*;
#(
  parameter int unsigned LVL_W  = 6,
  parameter int unsigned TRIG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              dma_en_i,
  input  logic              glb_en_i,
  input  logic              req_en_i,
  input  logic              fin_en_i,
  input  logic              done_i,
  input  logic              ovf_set_i,
  input  flags_t            clr_i,
  output flags_t            flags_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic   low;
  flags_t set, flg_q;

  assign low       = (level_i <= LVL_W'(trig_i));
  assign dma_req_o = dma_en_i && low;

  assign set.ovf = ovf_set_i;
  assign set.req = !dma_en_i && low;
  assign set.fin = done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= set | (flg_q & ~clr_i);
  end

  assign flags_o = flg_q;
  assign irq_o   = glb_en_i && ((flg_q.fin && fin_en_i) || (flg_q.req && req_en_i));
endmodule

// File: rtl/ledc_fifo_front.sv
module ledc_fifo_front
  import ledc_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned LEN_W    = 13,
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1),
  localparam int unsigned TRIG_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              xfer_done_i,
  output logic              run_o,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic [DW-1:0]     pix_data_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic              run_q, dma_en_q, glb_en_q, req_en_q, fin_en_q;
  logic [LEN_W-1:0]  len_q;
  logic [TRIG_W-1:0] trig_q;
  logic              wr_ctrl, wr_data, wr_dma, wr_ien, wr_stat, start;
  logic [LVL_W-1:0]  level;
  logic              full, empty;
  flags_t            flags, clr;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_data = reg_we_i && (reg_addr_i == A_DATA);
  assign wr_dma  = reg_we_i && (reg_addr_i == A_DMA);
  assign wr_ien  = reg_we_i && (reg_addr_i == A_IEN);
  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign start   = wr_ctrl && reg_wdata_i[B_RUN];

  assign clr.ovf = wr_stat && reg_wdata_i[B_OVF];
  assign clr.req = wr_stat && reg_wdata_i[B_REQ];
  assign clr.fin = wr_stat && reg_wdata_i[B_FIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      len_q    <= '0;
      dma_en_q <= 1'b0;
      trig_q   <= TRIG_W'(DEPTH / 2);
      glb_en_q <= 1'b0;
      req_en_q <= 1'b0;
      fin_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= reg_wdata_i[B_RUN];
        len_q <= reg_wdata_i[B_LEN +: LEN_W];
      end else if (xfer_done_i) begin
        run_q <= 1'b0;
      end
      if (wr_dma) begin
        dma_en_q <= reg_wdata_i[B_DMA_EN];
        trig_q   <= reg_wdata_i[TRIG_W-1:0];
      end
      if (wr_ien) begin
        glb_en_q <= reg_wdata_i[B_GLB_EN];
        req_en_q <= reg_wdata_i[B_REQ];
        fin_en_q <= reg_wdata_i[B_FIN];
      end
    end
  end

  assign pix_valid_o = run_q && !empty;

  ledc_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (start),
    .push_i  (wr_data),
    .wdata_i (reg_wdata_i),
    .pop_i   (pix_valid_o && pix_ready_i),
    .rdata_o (pix_data_o),
    .level_o (level),
    .full_o  (full),
    .empty_o (empty)
  );

  ledc_irq_ctrl #(.LVL_W(LVL_W), .TRIG_W(TRIG_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .trig_i    (trig_q),
    .dma_en_i  (dma_en_q),
    .glb_en_i  (glb_en_q),
    .req_en_i  (req_en_q),
    .fin_en_i  (fin_en_q),
    .done_i    (xfer_done_i),
    .ovf_set_i (wr_data && full),
    .clr_i     (clr),
    .flags_o   (flags),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[B_RUN]            = run_q;
        reg_rdata_o[B_LEN +: LEN_W]   = len_q;
      end
      A_DMA: begin
        reg_rdata_o[B_DMA_EN]         = dma_en_q;
        reg_rdata_o[TRIG_W-1:0]       = trig_q;
      end
      A_IEN: begin
        reg_rdata_o[B_GLB_EN]         = glb_en_q;
        reg_rdata_o[B_REQ]            = req_en_q;
        reg_rdata_o[B_FIN]            = fin_en_q;
      end
      A_STAT: begin
        reg_rdata_o[B_LVL +: LVL_W]   = level;
        reg_rdata_o[B_OVF]            = flags.ovf;
        reg_rdata_o[B_REQ]            = flags.req;
        reg_rdata_o[B_FIN]            = flags.fin;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign run_o       = run_q;
  assign frame_len_o = len_q;
endmodule

// File: rtl/ledc_fifo_front_chk.sv
module ledc_fifo_front_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LVL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] level,
  input logic             full,
  input logic             wr_data,
  input logic             start,
  input logic             dma_en_q,
  input logic             glb_en_q,
  input logic             ovf_flag,
  input logic             fin_flag,
  input logic             xfer_done_i,
  input logic             run_o,
  input logic             pix_valid_o,
  input logic             pix_ready_i,
  input logic [31:0]      pix_data_o,
  input logic             irq_o,
  input logic             dma_req_o
);
  // R3
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= LVL_W'(DEPTH));

  // R3
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && full) |=> ovf_flag);

  // R2
  pix_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> run_o);

  // R2
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i && !start && !xfer_done_i)
      |=> (pix_valid_o && $stable(pix_data_o)));

  // R5
  dma_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_q |-> !dma_req_o);

  // R7
  fin_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> (fin_flag && (!run_o || $past(start))));

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_q |-> !irq_o);

  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (level == '0 && run_o));
endmodule

bind ledc_fifo_front ledc_fifo_front_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .level       (level),
  .full        (full),
  .wr_data     (wr_data),
  .start       (start),
  .dma_en_q    (dma_en_q),
  .glb_en_q    (glb_en_q),
  .ovf_flag    (flags.ovf),
  .fin_flag    (flags.fin),
  .xfer_done_i (xfer_done_i),
  .run_o       (run_o),
  .pix_valid_o (pix_valid_o),
  .pix_ready_i (pix_ready_i),
  .pix_data_o  (pix_data_o),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o)
);

// File: tb/test_ledc_fifo_front.sv
`timescale 1ns/1ps
module test_ledc_fifo_front;
  localparam logic [4:0] A_CTRL = 5'h00, A_DATA = 5'h04, A_DMA = 5'h08,
                         A_IEN = 5'h0C, A_STAT = 5'h10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        xfer_done_i = 1'b0;
  logic        run_o;
  logic [12:0] frame_len_o;
  logic        pix_valid_o;
  logic        pix_ready_i = 1'b0;
  logic [31:0] pix_data_o;
  logic        irq_o, dma_req_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] q[$];

  always #2 clk_i = ~clk_i;

  ledc_fifo_front i_ledc_fifo_front (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #0.5 d = reg_rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic push(input logic [31:0] d);
    reg_wr(A_DATA, d);
    if (q.size() < 32) q.push_back(d);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      pix_ready_i = 1'b1;
      #0.5;
      check(pix_valid_o == 1'b1, "R2 valid", pix_valid_o, 1);
      check(pix_data_o == q[0], "R2 order", pix_data_o, q[0]);
      void'(q.pop_front());
    end
    @(negedge clk_i);
    pix_ready_i = 1'b0;
  endtask

  function automatic bit exp_irq(input bit g, input bit fe, input bit f, input bit re, input bit r);
    return g && ((fe && f) || (re && r));
  endfunction

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r;
    int n;
    void'($urandom(32'd4242));
    #9 rst_ni = 1'b1;

    // R1 reset state
    reg_rd(A_STAT, r);
    check(r[15:10] == 0 && r[2] == 0 && r[0] == 0, "R1 status", r, 0);
    reg_rd(A_DMA, r);
    check(r[4:0] == 16 && r[5] == 0, "R1 trigger", r, 16);
    check({irq_o, dma_req_o, run_o, pix_valid_o} == 4'b0, "R1 outputs",
          {irq_o, dma_req_o, run_o, pix_valid_o}, 0);

    // R10 start
    reg_wr(A_CTRL, (32'd50 << 16) | 32'd1);
    check(run_o == 1 && frame_len_o == 50, "R10 start", frame_len_o, 50);

    // R4 data reads zero
    push(32'hDEADBEEF);
    reg_rd(A_DATA, r);
    check(r == 0, "R4 data read", r, 0);
    drain(1);

    // random rounds: R2 R3 R6
    for (int rnd = 0; rnd < 12; rnd++) begin
      n = $urandom_range(1, 32 - q.size());
      for (int i = 0; i < n; i++) push($urandom);
      reg_wr(A_STAT, 32'h2);
      reg_rd(A_STAT, r);
      check(r[15:10] == q.size(), "R3 level", r[15:10], q.size());
      check(r[1] == (q.size() <= 16), "R6 request", r[1], (q.size() <= 16));
      drain($urandom_range(0, q.size()));
    end
    drain(q.size());

    // R3 full and overflow
    for (int i = 0; i < 34; i++) push(32'h1000 + i);
    reg_rd(A_STAT, r);
    check(r[15:10] == 32, "R3 full level", r[15:10], 32);
    check(r[2] == 1, "R3 overflow set", r[2], 1);
    // R8 write zero leaves flag
    reg_wr(A_STAT, 32'h0);
    reg_rd(A_STAT, r);
    check(r[2] == 1, "R8 zero write keeps", r[2], 1);
    reg_wr(A_STAT, 32'h4);
    reg_rd(A_STAT, r);
    check(r[2] == 0, "R8 overflow cleared", r[2], 0);
    drain(32);

    // R5 DMA mode, trigger 4
    reg_wr(A_DMA, 32'h20 | 32'd4);
    reg_wr(A_STAT, 32'h2);
    idle(2);
    check(dma_req_o == 1, "R5 dma empty", dma_req_o, 1);
    reg_rd(A_STAT, r);
    check(r[1] == 0, "R5 no request flag", r[1], 0);
    for (int i = 0; i < 4; i++) push(32'hA0 + i);
    #0.5 check(dma_req_o == 1, "R5 dma at trigger", dma_req_o, 1);
    push(32'hA4);
    #0.5 check(dma_req_o == 0, "R5 dma above trigger", dma_req_o, 0);

    // R6 processor mode at boundary
    reg_wr(A_DMA, 32'd4);
    #0.5 check(dma_req_o == 0, "R5 dma off", dma_req_o, 0);
    reg_wr(A_STAT, 32'h2);
    idle(2);
    reg_rd(A_STAT, r);
    check(r[1] == 0, "R6 above trigger", r[1], 0);
    drain(1);
    idle(1);
    reg_rd(A_STAT, r);
    check(r[1] == 1, "R6 at trigger", r[1], 1);

    // R9 interrupt combinations
    reg_wr(A_IEN, 32'h22);
    #0.5 check(irq_o == exp_irq(1, 0, 0, 1, 1), "R9 request irq", irq_o, 1);
    reg_wr(A_IEN, 32'h02);
    #0.5 check(irq_o == exp_irq(0, 0, 0, 1, 1), "R9 global off", irq_o, 0);

    // R7 finished
    @(negedge clk_i) xfer_done_i = 1'b1;
    @(negedge clk_i) xfer_done_i = 1'b0;
    reg_rd(A_STAT, r);
    check(r[0] == 1, "R7 finished flag", r[0], 1);
    check(run_o == 0, "R7 run cleared", run_o, 0);
    check(pix_valid_o == 0, "R2 no valid when stopped", pix_valid_o, 0);
    reg_wr(A_IEN, 32'h21);
    #0.5 check(irq_o == 1, "R9 finished irq", irq_o, 1);

    // R8 set wins over clear
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = A_STAT; reg_wdata_i = 32'h1; xfer_done_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; xfer_done_i = 1'b0;
    reg_rd(A_STAT, r);
    check(r[0] == 1, "R8 set wins", r[0], 1);
    reg_wr(A_STAT, 32'h1);
    reg_rd(A_STAT, r);
    check(r[0] == 0, "R8 finished cleared", r[0], 0);
    #0.5 check(irq_o == 0, "R9 irq drops", irq_o, 0);

    // R10 flush of leftovers
    reg_rd(A_STAT, r);
    check(r[15:10] == q.size(), "R3 leftover level", r[15:10], q.size());
    reg_wr(A_CTRL, (32'd7 << 16) | 32'd1);
    q.delete();
    reg_rd(A_STAT, r);
    check(r[15:10] == 0, "R10 flushed", r[15:10], 0);
    check(frame_len_o == 7 && run_o, "R10 length", frame_len_o, 7);
    push(32'h55);
    drain(1);

    summary();
  end
endmodule